// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and passes data between them in either direction. Each direction has its own capture register and its own clock. Each direction also has a source select that picks what reaches the far bus: the live value on the near bus, or the value held in that direction's register. The two output enables have opposite active levels. When both are inactive the block drives neither bus, and its registers can still be loaded.

No port is a tristate. Each bus side is split into an input from the bus, a data output and an output enable, and the surrounding logic resolves the wire. A register always captures the resolved bus, which is the block's own output when the block drives that side. This lets the block store the data it is passing through into the register of the opposite direction. The parameter `INVERT_OUT` makes every driven output the complement of its source. Register contents are stored as captured and are never complemented.

Top module: `regbus_xcvr`

## Requirements
- R1: The A-to-B register loads the resolved A bus on every rising edge of `clk_ab`, whatever the enables and selects are.
- R2: The B-to-A register loads the resolved B bus on every rising edge of `clk_ba`, whatever the enables and selects are.
- R3: `b_oe` is 1 exactly when `oe_ab` is 1, and `a_oe` is 1 exactly when `oe_ba_n` is 0. With `oe_ab`=0 and `oe_ba_n`=1 neither side is driven.
- R4: While B is driven, `sel_ab`=0 puts the live A bus on `b_out` and `sel_ab`=1 puts the A-to-B register on it.
- R5: While A is driven, `sel_ba`=0 puts the live B bus on `a_out` and `sel_ba`=1 puts the B-to-A register on it.
- R6: With both sides enabled and both selects at 1, B carries the A-to-B register and A carries the B-to-A register at the same time.
- R7: When the block drives one bus from the live opposite bus, a clock edge of the register that captures the driven bus stores the passed-through value. Both registers then hold data from the same source bus.
- R8: With `INVERT_OUT`=1 every driven output is the bitwise complement of its live or stored source, and the registers keep uncomplemented values.
- R9: When both clocks rise together, each register takes the value its bus had before the edge. With both selects at 1, the two register contents are therefore exchanged.
- R10: `rst_n` low clears both registers to zero at once, without a clock edge.
- R11: A data output whose enable is 0 is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_ab | input | 1 | Drive B side, active high |
| oe_ba_n | input | 1 | Drive A side, active low |
| sel_ab | input | 1 | B source: 0 live A, 1 stored |
| sel_ba | input | 1 | A source: 0 live B, 1 stored |
| a_in | input | WIDTH | Value on A bus from outside |
| a_out | output | WIDTH | Data driven onto A bus |
| a_oe | output | 1 | A side driver enable |
| b_in | input | WIDTH | Value on B bus from outside |
| b_out | output | WIDTH | Data driven onto B bus |
| b_oe | output | 1 | B side driver enable |

## Verification
The properties sample at the rising edges of the two direction clocks. They assume that the enables, selects and bus inputs are steady around each edge, and that the external driver is released whenever the block drives that side. The stimulus changes every control and bus value half a reference period away from the clock pulses. The external driver is switched off on any side the block enables, and the bench counts any overlap as a failure. The case where both directions are enabled in live mode forms a loop through the two buses, so the stimulus never produces it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  // True when a control pin sits at its active level.
  function automatic logic lvl_active(input logic pin, input logic active_high);
    return active_high ? pin : ~pin;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (q == $past(d))); // R1 R2

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH      = 8,
  parameter bit INVERT_OUT = 1'b0
) (
  input  xcvr_pkg::src_e   sel,
  input  logic             en,
  input  logic [WIDTH-1:0] stored,
  input  logic [WIDTH-1:0] live,
  output logic [WIDTH-1:0] drv_stored,
  output logic [WIDTH-1:0] out_data,
  output logic             out_en
);

  function automatic logic [WIDTH-1:0] shape(input logic [WIDTH-1:0] v);
    return INVERT_OUT ? ~v : v;
  endfunction

  assign drv_stored = shape(stored);
  assign out_en     = en;

  always_comb begin
    if (!en)                              out_data = '0;
    else if (sel == xcvr_pkg::SRC_STORED) out_data = drv_stored;
    else                                  out_data = shape(live);
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH      = 8,
  parameter bit INVERT_OUT = 1'b0
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  import xcvr_pkg::*;

  function automatic logic [WIDTH-1:0] shp(input logic [WIDTH-1:0] v);
    return INVERT_OUT ? ~v : v;
  endfunction

  logic             en_a, en_b;
  src_e             src_ab, src_ba;
  logic [WIDTH-1:0] q_ab, q_ba;
  logic [WIDTH-1:0] a_stored_drv, b_stored_drv;
  logic [WIDTH-1:0] a_src_for_b, b_src_for_a;
  logic [WIDTH-1:0] a_bus, b_bus;

  assign en_b   = lvl_active(oe_ab, 1'b1);
  assign en_a   = lvl_active(oe_ba_n, 1'b0);
  assign src_ab = src_e'(sel_ab);
  assign src_ba = src_e'(sel_ba);

  // The live source of one direction is the far bus; when the block drives
  // that bus from storage, the stored drive value is used. This keeps the
  // path acyclic.
  assign a_src_for_b = (en_a && src_ba == SRC_STORED) ? a_stored_drv : a_in;
  assign b_src_for_a = (en_b && src_ab == SRC_STORED) ? b_stored_drv : b_in;

  // Resolved bus values seen by the capture registers.
  assign a_bus = a_oe ? a_out : a_in;
  assign b_bus = b_oe ? b_out : b_in;

  xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_bus), .q(q_ab)
  );

  xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_bus), .q(q_ba)
  );

  xcvr_lane #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) u_lane_ab (
    .sel(src_ab), .en(en_b), .stored(q_ab), .live(a_src_for_b),
    .drv_stored(b_stored_drv), .out_data(b_out), .out_en(b_oe)
  );

  xcvr_lane #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) u_lane_ba (
    .sel(src_ba), .en(en_a), .stored(q_ba), .live(b_src_for_a),
    .drv_stored(a_stored_drv), .out_data(a_out), .out_en(a_oe)
  );

  AST_B_STORED: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (oe_ab && sel_ab) |-> (b_out == shp(q_ab))); // R4

  AST_A_STORED: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_ba_n && sel_ba) |-> (a_out == shp(q_ba))); // R5

  AST_B_LIVE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (oe_ab && !sel_ab && oe_ba_n) |-> (b_out == shp(a_in))); // R4

  AST_ISOLATION: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_ab && oe_ba_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R3

  AST_LOOPBACK: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (oe_ab && !sel_ab && oe_ba_n) |-> (b_out == shp(a_in))); // R7

endmodule

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;

  localparam int W = 8;

  typedef struct packed {
    logic         oe_ab, oe_ba_n, sel_ab, sel_ba;
    logic         a_en;
    logic [W-1:0] a_val;
    logic         b_en;
    logic [W-1:0] b_val;
    logic         p_ab, p_ba;
    logic [W-1:0] exp_a, exp_b;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h11, 1'b1,8'h22, 1'b1,1'b1, 8'h11,8'h22},
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h33, 1'b1,8'h44, 1'b0,1'b0, 8'h33,8'h44},
    '{1'b1,1'b1,1'b1,1'b0, 1'b1,8'h55, 1'b0,8'h00, 1'b0,1'b0, 8'h55,8'h11},
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h55, 1'b0,8'h00, 1'b0,1'b0, 8'h55,8'h55},
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h66, 1'b0,8'h00, 1'b1,1'b1, 8'h66,8'h66},
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,8'h00, 1'b1,8'h77, 1'b0,1'b0, 8'h66,8'h77},
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b1,8'h77, 1'b0,1'b0, 8'h77,8'h77},
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b1,8'h88, 1'b1,1'b0, 8'h88,8'h88},
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h66,8'h88},
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h12, 1'b1,8'h34, 1'b1,1'b1, 8'h12,8'h34},
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h34,8'h12},
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1, 8'h12,8'h34},
    '{1'b1,1'b1,1'b1,1'b0, 1'b1,8'h9A, 1'b0,8'h00, 1'b1,1'b0, 8'h9A,8'h9A}
  };

  localparam string TAG [NV] = '{
    "R1 R2 R3", "R3", "R4", "R4", "R7 R9", "R5", "R5", "R7 R1",
    "R6", "R1 R2", "R6", "R9", "R1"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic a_en = 1'b0, b_en = 1'b0;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic [W-1:0] a_out, b_out, ai_out, bi_out;
  logic a_oe, b_oe, ai_oe, bi_oe;
  logic [W-1:0] a_wire, b_wire;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .INVERT_OUT(1'b0)) uut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_ext), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_ext), .b_out(b_out), .b_oe(b_oe)
  );

  regbus_xcvr #(.WIDTH(W), .INVERT_OUT(1'b1)) uut_inv (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_ext), .a_out(ai_out), .a_oe(ai_oe),
    .b_in(b_ext), .b_out(bi_out), .b_oe(bi_oe)
  );

  // Bench-side bus resolution.
  assign a_wire = a_oe ? a_out : a_ext;
  assign b_wire = b_oe ? b_out : b_ext;

  task automatic check(input logic ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    oe_ab = v.oe_ab; oe_ba_n = v.oe_ba_n; sel_ab = v.sel_ab; sel_ba = v.sel_ba;
    a_en = v.a_en; a_ext = v.a_val; b_en = v.b_en; b_ext = v.b_val;
    @(posedge clk);
    clk_ab = v.p_ab; clk_ba = v.p_ba;
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
    #2;
  endtask

  task automatic contention(input string tag);
    check(!(a_oe && a_en), {tag, " A contention"}, {7'd0, a_oe}, '0);
    check(!(b_oe && b_en), {tag, " B contention"}, {7'd0, b_oe}, '0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    // R10: reset state seen through both stored paths.
    oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(a_out == 8'h00 && b_out == 8'h00, "R10 reset value", {a_out[3:0], b_out[3:0]}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      contention(TAG[i]);
      check(a_wire == VEC[i].exp_a, {TAG[i], " A bus"}, a_wire, VEC[i].exp_a);
      check(b_wire == VEC[i].exp_b, {TAG[i], " B bus"}, b_wire, VEC[i].exp_b);
      check(a_oe == !VEC[i].oe_ba_n && b_oe == VEC[i].oe_ab, "R3 enable polarity",
            {6'd0, a_oe, b_oe}, {6'd0, !VEC[i].oe_ba_n, VEC[i].oe_ab});
    end

    // R11: disabled outputs are zero in isolation.
    v = '{1'b0,1'b1,1'b0,1'b1, 1'b1,8'h5A, 1'b1,8'hA5, 1'b0,1'b0, 8'h5A,8'hA5};
    apply(v);
    check(a_out == 8'h00, "R11 A data while disabled", a_out, 8'h00);
    check(b_out == 8'h00, "R11 B data while disabled", b_out, 8'h00);

    // R10: reset mid-run with no clock edge.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    v = '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h00,8'h00};
    apply(v);
    check(a_wire == 8'h00, "R10 A register cleared", a_wire, 8'h00);
    check(b_wire == 8'h00, "R10 B register cleared", b_wire, 8'h00);

    // R8: inverting variant, stored value kept true.
    v = '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h0F, 1'b1,8'h00, 1'b1,1'b0, 8'h0F,8'h00};
    apply(v);
    v = '{1'b1,1'b1,1'b1,1'b0, 1'b1,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h00,8'h0F};
    apply(v);
    check(bi_out == 8'hF0, "R8 stored output complemented", bi_out, 8'hF0);
    check(b_out == 8'h0F, "R8 true variant stored", b_out, 8'h0F);
    v = '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h3C, 1'b0,8'h00, 1'b0,1'b0, 8'h3C,8'h3C};
    apply(v);
    check(bi_out == 8'hC3, "R8 live output complemented", bi_out, 8'hC3);
    check(bi_oe == 1'b1 && ai_oe == 1'b0, "R8 variant enables", {6'd0, ai_oe, bi_oe}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule